// File: doc/BRIEF.md
# Address Monitor Tracking Table

This block keeps a small shared table of cache-line addresses that hardware threads have armed with monitor requests. A write snoop whose line address hits an armed entry frees that entry and sends a one-cycle wake pulse to the owning thread. Threads use the wake to leave a low-power wait.

The table has a fixed number of slots, so it needs a defined behaviour when it is full. A static policy input selects between two options. In broadcast mode the table stops filtering and every write snoop wakes all threads until occupancy drops to a programmable low watermark. In reject mode the table refuses the request and reports it as not accepted.

Two control bits shape arming:
- An ignore-user bit drops user-level requests.
- A flush bit makes each accepted request first clear every entry held by the requester's sibling group. This recovers space and can end overflow early.

Top module: `monitor_table`

## Requirements
- R1: After reset the table is empty and overflow mode is off. The ignore-user bit reads 1 and the flush bit reads 0. `rsp_valid`, `rsp_ok`, `wake` and `ovf_mode` are all 0.
- R2: Every request cycle produces `rsp_valid`=1 exactly one cycle later. A handled request that finds a free slot gets `rsp_ok`=1.
- R3: A write snoop outside overflow mode frees each valid entry whose line matches. One cycle later it raises `wake[t]` for each owning thread t, where bit t of `wake` belongs to thread ID t. A repeat snoop to a freed line wakes nobody.
- R4: While `ovf_mode` is 1, every write snoop drives all `wake` bits to 1 one cycle later.
- R5: With `cfg_reject`=0, a handled request that finds the table full gets `rsp_ok`=1 and puts the table into overflow mode. `ovf_mode` becomes 1 one cycle later.
- R6: With `cfg_reject`=1, a handled request that finds the table full gets `rsp_ok`=0, and `ovf_mode` does not rise.
- R7: While the ignore-user bit is 1, a request with `req_priv`=0 gets `rsp_ok`=0 and takes no slot. It produces no wake and no change to overflow. Requests with `req_priv`=1 are still handled normally.
- R8: While the flush bit is 1, a handled request first invalidates every entry whose thread ID shifted right by `SIB_LOG` equals the requester's. Only then does it look for a free slot.
- R9: Each thread other than the requester that loses an entry to the R8 flush gets a wake pulse one cycle later. The requester itself is not woken by the flush.
- R10: Overflow mode ends after any cycle whose resulting occupancy is at or below `cfg_lowmark`. From the cycle in which `ovf_mode` reads 0, snoops are filtered again.
- R11: A snoop and a request in the same cycle are applied in order: the snoop first. An entry freed by the snoop is available to that same request.
- R12: A cycle with `cfg_wr`=1 loads the ignore-user bit from `cfg_ign_user` and the flush bit from `cfg_flush`. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Monitor request strobe |
| req_tid | input | TID_W | Requesting thread ID |
| req_line | input | LINE_W | Line address to arm |
| req_priv | input | 1 | 1 = privileged request, 0 = user-level |
| snp_valid | input | 1 | Write snoop strobe |
| snp_line | input | LINE_W | Line address written |
| cfg_wr | input | 1 | Load both control bits |
| cfg_ign_user | input | 1 | New ignore-user value |
| cfg_flush | input | 1 | New flush-mitigation value |
| cfg_reject | input | 1 | Full-table policy: 1 = reject, 0 = broadcast |
| cfg_lowmark | input | CNT_W | Occupancy at or below which overflow mode ends |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_ok | output | 1 | That request was accepted |
| wake | output | N_THR | Per-thread wake pulses |
| ovf_mode | output | 1 | Table is in broadcast overflow mode |

## Verification
A snoop and a request can land in the same cycle. The snoop can also free the very slot the request needs, and under the flush bit both sources can raise wakes at once. The bench provokes this in two ways. A directed step snoops one line of a full table in reject mode while a new request arrives. A random phase draws snoops and requests from a small address pool, so coincident hits are frequent. The outcome is judged by a bench model that applies snoop, then flush, then allocation, then the watermark test. Its predicted `rsp_ok`, `wake` and `ovf_mode` are compared one cycle later.

// File: rtl/mt_pkg.sv
package mt_pkg;
    typedef enum logic {
        MT_FULL_BCAST  = 1'b0,
        MT_FULL_REJECT = 1'b1
    } mt_full_e;
endpackage

// File: rtl/mt_match.sv
module mt_match #(
    parameter int N = 8,
    parameter int W = 26
) (
    input  logic [N-1:0]        vld,
    input  logic [N-1:0][W-1:0] tag,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = vld[i] && (tag[i] == key);
    end
endmodule

// File: rtl/mt_first_free.sv
module mt_first_free #(
    parameter int N = 8
) (
    input  logic [N-1:0] vld,
    output logic [N-1:0] sel,
    output logic         any_free
);
    // lowest clear bit of vld as a one-hot vector
    assign sel      = ~vld & (vld + N'(1));
    assign any_free = ~&vld;
endmodule

// File: rtl/monitor_table.sv
module monitor_table
    import mt_pkg::*;
#(
    parameter  int N_ENT   = 8,
    parameter  int N_THR   = 4,
    parameter  int LINE_W  = 26,
    parameter  int SIB_LOG = 1,
    localparam int TID_W   = (N_THR > 1) ? $clog2(N_THR) : 1,
    localparam int CNT_W   = $clog2(N_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [LINE_W-1:0] req_line,
    input  logic              req_priv,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              cfg_wr,
    input  logic              cfg_ign_user,
    input  logic              cfg_flush,
    input  logic              cfg_reject,
    input  logic [CNT_W-1:0]  cfg_lowmark,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [N_THR-1:0]  wake,
    output logic              ovf_mode
);
    typedef struct packed {
        logic [N_ENT-1:0]             vld;
        logic [N_ENT-1:0][TID_W-1:0]  tid;
        logic [N_ENT-1:0][LINE_W-1:0] line;
        logic                         ovf;
        logic                         ign_user;
        logic                         flush_en;
        logic [N_THR-1:0]             wake;
        logic                         rsp_v;
        logic                         rsp_ok;
    } state_t;

    state_t st_q, st_d;

    logic [N_ENT-1:0]            snp_hit, snp_hit_m, grp_hit, fl_hit, vld_b, free_sel;
    logic [N_ENT-1:0][TID_W-1:0] grp_tag;
    logic [TID_W-1:0]            req_grp;
    logic                        any_free, go, new_ovf, ign_user_q;
    logic [CNT_W-1:0]            occ;
    mt_full_e                    policy;

    for (genvar g = 0; g < N_ENT; g++) begin : g_grp
        assign grp_tag[g] = st_q.tid[g] >> SIB_LOG;
    end
    assign req_grp = req_tid >> SIB_LOG;

    mt_match #(.N(N_ENT), .W(LINE_W)) u_snp (
        .vld(st_q.vld), .tag(st_q.line), .key(snp_line), .hit(snp_hit)
    );
    mt_match #(.N(N_ENT), .W(TID_W)) u_grp (
        .vld(st_q.vld), .tag(grp_tag), .key(req_grp), .hit(grp_hit)
    );

    // ordering within a cycle: snoop, then flush, then allocation
    assign policy    = mt_full_e'(cfg_reject);
    assign go        = req_valid && (req_priv || !st_q.ign_user);
    assign snp_hit_m = snp_valid ? snp_hit : '0;
    assign fl_hit    = (go && st_q.flush_en) ? (grp_hit & ~snp_hit_m) : '0;
    assign vld_b     = st_q.vld & ~snp_hit_m & ~fl_hit;

    mt_first_free #(.N(N_ENT)) u_free (
        .vld(vld_b), .sel(free_sel), .any_free(any_free)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = vld_b;
        st_d.wake   = '0;
        st_d.rsp_v  = req_valid;
        st_d.rsp_ok = 1'b0;
        new_ovf     = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (snp_hit_m[i]) st_d.wake[st_q.tid[i]] = 1'b1;
            if (fl_hit[i] && (st_q.tid[i] != req_tid)) st_d.wake[st_q.tid[i]] = 1'b1;
        end
        if (snp_valid && st_q.ovf) st_d.wake = '1;
        if (go) begin
            if (any_free) begin
                st_d.rsp_ok = 1'b1;
                for (int i = 0; i < N_ENT; i++) begin
                    if (free_sel[i]) begin
                        st_d.vld[i]  = 1'b1;
                        st_d.tid[i]  = req_tid;
                        st_d.line[i] = req_line;
                    end
                end
            end else if (policy == MT_FULL_BCAST) begin
                st_d.rsp_ok = 1'b1;
                new_ovf     = 1'b1;
            end
        end
        occ = '0;
        for (int i = 0; i < N_ENT; i++) occ = occ + CNT_W'(st_d.vld[i]);
        st_d.ovf = new_ovf || (st_q.ovf && (occ > cfg_lowmark));
        if (cfg_wr) begin
            st_d.ign_user = cfg_ign_user;
            st_d.flush_en = cfg_flush;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ign_user <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_v;
    assign rsp_ok     = st_q.rsp_ok;
    assign wake       = st_q.wake;
    assign ovf_mode   = st_q.ovf;
    assign ign_user_q = st_q.ign_user;
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int N_THR = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_priv,
    input logic             snp_valid,
    input logic             cfg_reject,
    input logic             ign_user_q,
    input logic             rsp_valid,
    input logic             rsp_ok,
    input logic [N_THR-1:0] wake,
    input logic             ovf_mode
);
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_bcast_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_mode && snp_valid) |=> (wake == '1));
    p_ovf_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_mode && !req_valid) |=> !ovf_mode);
    p_reject_no_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_mode && cfg_reject) |=> !ovf_mode);
    p_user_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && ign_user_q) |=> (rsp_valid && !rsp_ok));
    p_quiet_no_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_valid && !req_valid) |=> (wake == '0));
endmodule

bind monitor_table mt_checker #(.N_THR(N_THR)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .snp_valid(snp_valid), .cfg_reject(cfg_reject), .ign_user_q(ign_user_q),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .wake(wake), .ovf_mode(ovf_mode)
);

// File: tb/sim_monitor_table.sv
`timescale 1ns/1ps
module sim_monitor_table;
    localparam int NE = 8, NT = 4, LW = 26, TW = 2, CW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_priv = 0, snp_valid = 0, cfg_wr = 0;
    logic cfg_ign_user = 0, cfg_flush = 0, cfg_reject = 0;
    logic [TW-1:0] req_tid = '0;
    logic [LW-1:0] req_line = '0, snp_line = '0;
    logic [CW-1:0] cfg_lowmark = '0;
    logic rsp_valid, rsp_ok, ovf_mode;
    logic [NT-1:0] wake;

    always #2.5 clk = ~clk;

    monitor_table u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
        .req_line(req_line), .req_priv(req_priv), .snp_valid(snp_valid),
        .snp_line(snp_line), .cfg_wr(cfg_wr), .cfg_ign_user(cfg_ign_user),
        .cfg_flush(cfg_flush), .cfg_reject(cfg_reject), .cfg_lowmark(cfg_lowmark),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .wake(wake), .ovf_mode(ovf_mode)
    );

    int chk = 0, err = 0;
    bit done = 0;
    bit mv[NE];
    int mt[NE], ml[NE];
    bit movf = 0, mign = 1, mflush = 0;

    task automatic check(input bit c, input string tag, input string what,
                         input int act, input int exp);
        chk++;
        if (!c) begin
            err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // bench model of one cycle: snoop, then flush, then allocation, then watermark
    function automatic void model(input bit rv, input int tid, input int ln, input bit pr,
                                  input bit sv, input int sl, input bit cw, input bit ci,
                                  input bit cf, output int ew, output bit eok);
        bit nov = 0;
        int fi = -1, cnt = 0;
        ew = 0; eok = 0;
        if (sv) begin
            for (int i = 0; i < NE; i++)
                if (mv[i] && ml[i] == sl) begin mv[i] = 0; ew |= 1 << mt[i]; end
            if (movf) ew = 15;
        end
        if (rv && (pr || !mign)) begin
            if (mflush)
                for (int i = 0; i < NE; i++)
                    if (mv[i] && (mt[i] >> 1) == (tid >> 1)) begin
                        mv[i] = 0;
                        if (mt[i] != tid) ew |= 1 << mt[i];
                    end
            for (int i = 0; i < NE; i++) if (!mv[i] && fi < 0) fi = i;
            if (fi >= 0) begin mv[fi] = 1; mt[fi] = tid; ml[fi] = ln; eok = 1; end
            else if (!cfg_reject) begin eok = 1; nov = 1; end
        end
        for (int i = 0; i < NE; i++) cnt += int'(mv[i]);
        movf = nov || (movf && cnt > int'(cfg_lowmark));
        if (cw) begin mign = ci; mflush = cf; end
    endfunction

    task automatic cyc(input bit rv, input int tid, input int ln, input bit pr,
                       input bit sv, input int sl, input bit cw, input bit ci,
                       input bit cf, input string tag);
        int ew; bit eok;
        req_valid = rv; req_tid = TW'(tid); req_line = LW'(ln); req_priv = pr;
        snp_valid = sv; snp_line = LW'(sl);
        cfg_wr = cw; cfg_ign_user = ci; cfg_flush = cf;
        @(posedge clk);
        model(rv, tid, ln, pr, sv, sl, cw, ci, cf, ew, eok);
        @(negedge clk);
        check(rsp_valid == rv && rsp_ok == eok, tag, "rsp",
              {rsp_valid, rsp_ok}, {rv, eok});
        check(wake == NT'(ew), tag, "wake", wake, ew);
        check(ovf_mode == movf, tag, "ovf", ovf_mode, movf);
    endtask

    task automatic req(input int tid, input int ln, input bit pr, input string tag);
        cyc(1, tid, ln, pr, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic snp(input int sl, input string tag);
        cyc(0, 0, 0, 0, 1, sl, 0, 0, 0, tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        check(rsp_valid == 0 && rsp_ok == 0, "R1", "rsp", {rsp_valid, rsp_ok}, 0);
        check(wake == 0, "R1", "wake", wake, 0);
        check(ovf_mode == 0, "R1", "ovf", ovf_mode, 0);
        rst_n = 1'b1;
        // R1/R7: ignore-user defaults to 1, user request refused
        req(0, 1, 0, "R7");
        check(rsp_ok == 0, "R1", "user ok", rsp_ok, 0);
        // R7/R2: privileged still armed; R3 wake then no repeat wake
        req(2, 10, 1, "R2");
        snp(10, "R3");
        check(wake == 4'b0100, "R3", "wake", wake, 4'b0100);
        snp(10, "R3");
        // R6: fill, then reject
        cfg_reject = 1;
        for (int i = 0; i < NE; i++) req(i % 4, 20 + i, 1, "R2");
        req(3, 40, 1, "R6");
        check(rsp_ok == 0 && ovf_mode == 0, "R6", "reject", {rsp_ok, ovf_mode}, 0);
        // R5: broadcast policy enters overflow; R4 snoop wakes all
        cfg_reject = 0;
        req(3, 40, 1, "R5");
        check(ovf_mode == 1, "R5", "ovf", ovf_mode, 1);
        snp(99, "R4");
        check(wake == 4'hF, "R4", "wake", wake, 4'hF);
        // R10: exit at watermark, filtering resumes
        cfg_lowmark = 4'd6;
        snp(20, "R10");
        snp(21, "R10");
        check(ovf_mode == 0, "R10", "ovf exit", ovf_mode, 0);
        snp(22, "R10");
        check(wake == 4'b0100, "R10", "filtered", wake, 4'b0100);
        // R11: snoop frees the slot used by the same-cycle request
        cfg_reject = 1;
        req(0, 50, 1, "R11"); req(0, 51, 1, "R11"); req(0, 52, 1, "R11");
        cyc(1, 1, 60, 1, 1, 23, 0, 0, 0, "R11");
        check(rsp_ok == 1 && wake == 4'b1000, "R11", "ok/wake", {rsp_ok, wake}, 5'b11000);
        // R12: control write; R8/R9 flush of group 0 on a full table
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, "R12");
        req(0, 70, 0, "R8");
        check(rsp_ok == 1, "R8", "ok after flush", rsp_ok, 1);
        check(wake == 4'b0010, "R9", "sibling wake", wake, 4'b0010);
        snp(25, "R9");
        check(wake == 0, "R8", "flushed line", wake, 0);
        snp(70, "R12");
        check(wake == 4'b0001, "R12", "user armed", wake, 4'b0001);
        // random mix against the model
        for (int k = 0; k < 800; k++) begin
            if ($urandom % 32 == 0) cfg_reject = ~cfg_reject;
            if ($urandom % 16 == 0) cfg_lowmark = CW'($urandom % 9);
            cyc($urandom % 2, $urandom % 4, $urandom % 6, $urandom % 2,
                ($urandom % 3) == 0, $urandom % 6, ($urandom % 20) == 0,
                $urandom % 2, $urandom % 2, "R3");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", chk, err);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            chk++; err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", chk, err);
            $finish;
        end
    end
endmodule